// File: doc/BRIEF.md
# Per-Block Lock State Controller

This block holds the protection state of every erase block in a boot-block flash memory model with 23 blocks: eight 4K-word parameter blocks and fifteen 32K-word main blocks on a 19-bit word address. Each block is unlocked, locked or locked-down. A command decoder forwards its bus writes to the block. A two-write sequence locks, unlocks or locks down the block that the second write addresses. A write-protect input decides whether lock-down freezes a block's state.

A second address input selects one block for reporting. The block returns a signature word with that block's lock and lock-down bits. It also returns a permission flag that the program/erase controller samples before it starts an operation. Full per-block state vectors are also brought out. A parameter selects the top-boot or the bottom-boot address layout.

Top module: `blk_prot_ctrl`

## Requirements
- R1: With TOP_BOOT=1, addresses below 78000h map to block index addr[18:15] (0..14), and addresses from 78000h upward map to index 15 + addr[14:12] (15..22).
- R2: With TOP_BOOT=0, addresses below 08000h map to block index addr[14:12] (0..7), and all other addresses map to index addr[18:15] + 7 (8..22).
- R3: While rst_n is low, and after it rises, every block is locked (lock bit 1) and no block is locked-down (lock-down bit 0).
- R4: A write with cmd_valid=1 and cmd_data=60h arms the sequence. The next write ends the sequence. That write applies lock (01h), unlock (D0h) or lock-down (2Fh) to the block at its cmd_addr, and any other data value changes nothing. A write that arrives while the sequence is not armed and is not 60h changes nothing.
- R5: While wp_n is low, a locked-down block ignores lock, unlock and lock-down requests, and its lock bit does not change.
- R6: An accepted lock-down request sets both the lock bit and the lock-down bit of the block.
- R7: No command clears a lock-down bit. Only reset clears it, and the block then returns to locked.
- R8: While wp_n is high, a locked-down block accepts lock and unlock and keeps its lock-down bit. A block left unlocked this way reports bit 0 = 0 and bit 1 = 1.
- R9: sig_data for the block at qry_addr carries bit 0 = lock bit and bit 1 = lock-down bit. All other bits are zero.
- R10: pe_allow is 1 exactly when the block at qry_addr is unlocked.
- R11: lock_bits[i] and down_bits[i] give the lock and lock-down bits of block index i. The state update of a write is visible on these outputs after the clock edge that samples that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cmd_valid | input | 1 | One-cycle strobe for a bus write from the command decoder |
| cmd_data | input | 8 | Command data of the write |
| cmd_addr | input | 19 | Word address of the write |
| wp_n | input | 1 | Write protect; low makes lock-down freeze a block |
| qry_addr | input | 19 | Word address of the block being reported |
| sig_data | output | 16 | Lock signature of the reported block |
| pe_allow | output | 1 | Program/erase permitted for the reported block |
| lock_bits | output | 23 | Lock bit of every block |
| down_bits | output | 23 | Lock-down bit of every block |

## Verification
Assertions check the following on every cycle: the freeze while write protect is low, that a lock-down bit never clears outside reset, that a lock-down bit never rises without the lock bit, that the sequencer disarms after any write while armed, and that unselected blocks hold their state. Only the bench's scenarios show the rest. These are the exact index at each region boundary in both layouts, that a mismatched second write or a doubled setup write changes nothing, the unlocked-but-locked-down state reached with write protect high, and the reset return from lock-down to locked. A behavioural model of both layouts is compared with every output on every clock.

// File: rtl/blkprot_pkg.sv
package blkprot_pkg;

   typedef enum logic [1:0] {
      OP_NONE   = 2'd0,
      OP_LOCK   = 2'd1,
      OP_UNLOCK = 2'd2,
      OP_DOWN   = 2'd3
   } prot_op_e;

   localparam logic [7:0] CODE_SETUP  = 8'h60;
   localparam logic [7:0] CODE_LOCK   = 8'h01;
   localparam logic [7:0] CODE_UNLOCK = 8'hD0;
   localparam logic [7:0] CODE_DOWN   = 8'h2F;

endpackage

// File: rtl/blkprot_addr_map.sv
module blkprot_addr_map #(
   parameter int ADDR_W   = 19,
   parameter int PARAM_W  = 12,
   parameter int MAIN_W   = 15,
   parameter int N_PARAM  = 8,
   parameter int N_MAIN   = 15,
   parameter bit TOP_BOOT = 1'b1,
   parameter int IDX_W    = 5
) (
   input  logic [ADDR_W-PARAM_W-1:0] hi_addr,
   output logic [IDX_W-1:0]          blk_idx
);

   localparam int SLOT_W = ADDR_W - MAIN_W;
   localparam int SUB_W  = MAIN_W - PARAM_W;

   if ((N_PARAM << PARAM_W) != (1 << MAIN_W)) begin : g_bad_param_fill
      $error("parameter blocks must fill exactly one main-block slot");
   end
   if (N_MAIN + 1 != (1 << SLOT_W)) begin : g_bad_main_count
      $error("main blocks plus the parameter slot must cover the address space");
   end
   if ((1 << IDX_W) < N_PARAM + N_MAIN) begin : g_bad_idx_w
      $error("index width too small for the block count");
   end

   logic [SLOT_W-1:0] slot;
   logic [SUB_W-1:0]  sub;

   assign slot = hi_addr[SUB_W +: SLOT_W];
   assign sub  = hi_addr[SUB_W-1:0];

   if (TOP_BOOT) begin : g_top
      always_comb begin
         if (slot == '1) blk_idx = IDX_W'(N_MAIN) + IDX_W'(sub);
         else            blk_idx = IDX_W'(slot);
      end
   end else begin : g_bottom
      always_comb begin
         if (slot == '0) blk_idx = IDX_W'(sub);
         else            blk_idx = IDX_W'(slot) + IDX_W'(N_PARAM - 1);
      end
   end

endmodule

// File: rtl/blkprot_cmd_seq.sv
module blkprot_cmd_seq
   import blkprot_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [7:0] cmd_data,
   output prot_op_e   op
);

   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          armed_q <= 1'b0;
      else if (cmd_valid)  armed_q <= !armed_q && (cmd_data == CODE_SETUP);
   end

   always_comb begin
      op = OP_NONE;
      if (cmd_valid && armed_q) begin
         case (cmd_data)
            CODE_LOCK:   op = OP_LOCK;
            CODE_UNLOCK: op = OP_UNLOCK;
            CODE_DOWN:   op = OP_DOWN;
            default:     op = OP_NONE;
         endcase
      end
   end

   // R4: any write while armed ends the sequence
   assert_disarm_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && cmd_valid) |=> !armed_q);

   // R4: a setup write while idle arms the sequence
   assert_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_q && cmd_valid && cmd_data == CODE_SETUP) |=> armed_q);

endmodule

// File: rtl/blkprot_cell.sv
module blkprot_cell
   import blkprot_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     sel,
   input  prot_op_e op,
   input  logic     wp_n,
   output logic     lock_o,
   output logic     down_o
);

   logic lock_q, down_q, frozen;

   assign frozen = down_q && !wp_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= 1'b1;
         down_q <= 1'b0;
      end else if (sel && !frozen) begin
         case (op)
            OP_LOCK:   lock_q <= 1'b1;
            OP_UNLOCK: lock_q <= 1'b0;
            OP_DOWN: begin
               lock_q <= 1'b1;
               down_q <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign lock_o = lock_q;
   assign down_o = down_q;

   // R5: locked-down with write protect low freezes the lock bit
   assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (down_q && !wp_n) |=> (lock_q == $past(lock_q)));

   // R7: lock-down is never cleared by a command
   assert_down_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      down_q |=> down_q);

   // R6: entering lock-down always leaves the block locked
   assert_down_locks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(down_q) |-> lock_q);

   // R4: a block not addressed by the write keeps its state
   assert_unsel_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> $stable({lock_q, down_q}));

endmodule

// File: rtl/blk_prot_ctrl.sv
module blk_prot_ctrl
   import blkprot_pkg::*;
#(
   parameter int ADDR_W   = 19,
   parameter int PARAM_W  = 12,
   parameter int MAIN_W   = 15,
   parameter int N_PARAM  = 8,
   parameter int N_MAIN   = 15,
   parameter bit TOP_BOOT = 1'b1,
   parameter int SIG_W    = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cmd_valid,
   input  logic [7:0]                  cmd_data,
   input  logic [ADDR_W-1:0]           cmd_addr,
   input  logic                        wp_n,
   input  logic [ADDR_W-1:0]           qry_addr,
   output logic [SIG_W-1:0]            sig_data,
   output logic                        pe_allow,
   output logic [N_PARAM+N_MAIN-1:0]   lock_bits,
   output logic [N_PARAM+N_MAIN-1:0]   down_bits
);

   localparam int N_BLK = N_PARAM + N_MAIN;
   localparam int IDX_W = $clog2(N_BLK);
   localparam int HI_W  = ADDR_W - PARAM_W;

   if (SIG_W < 2) begin : g_bad_sig_w
      $error("signature word needs at least two bits");
   end

   prot_op_e         op;
   logic [IDX_W-1:0] cmd_idx, qry_idx;
   logic             unused_low;

   assign unused_low = ^{cmd_addr[PARAM_W-1:0], qry_addr[PARAM_W-1:0]};

   blkprot_cmd_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_valid(cmd_valid),
      .cmd_data (cmd_data),
      .op       (op)
   );

   blkprot_addr_map #(
      .ADDR_W(ADDR_W), .PARAM_W(PARAM_W), .MAIN_W(MAIN_W),
      .N_PARAM(N_PARAM), .N_MAIN(N_MAIN), .TOP_BOOT(TOP_BOOT), .IDX_W(IDX_W)
   ) u_cmd_map (
      .hi_addr(cmd_addr[ADDR_W-1:PARAM_W]),
      .blk_idx(cmd_idx)
   );

   blkprot_addr_map #(
      .ADDR_W(ADDR_W), .PARAM_W(PARAM_W), .MAIN_W(MAIN_W),
      .N_PARAM(N_PARAM), .N_MAIN(N_MAIN), .TOP_BOOT(TOP_BOOT), .IDX_W(IDX_W)
   ) u_qry_map (
      .hi_addr(qry_addr[ADDR_W-1:PARAM_W]),
      .blk_idx(qry_idx)
   );

   for (genvar g = 0; g < N_BLK; g++) begin : g_cell
      blkprot_cell u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .sel   (cmd_idx == IDX_W'(g)),
         .op    (op),
         .wp_n  (wp_n),
         .lock_o(lock_bits[g]),
         .down_o(down_bits[g])
      );
   end

   assign sig_data = SIG_W'({down_bits[qry_idx], lock_bits[qry_idx]});
   assign pe_allow = !lock_bits[qry_idx];

   // R1: decoded indices always name an existing block
   assert_qry_idx_R1: assert property (@(posedge clk) disable iff (!rst_n)
      qry_idx < IDX_W'(N_BLK));
   assert_cmd_idx_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_idx < IDX_W'(N_BLK));

endmodule

// File: tb/test_blk_prot_ctrl.sv
`timescale 1ns/1ps
module test_blk_prot_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [7:0]  cmd_data = 8'h00;
   logic [18:0] cmd_addr = '0;
   logic        wp_n = 1'b0;
   logic [18:0] qry_addr = '0;

   logic [15:0] t_sig, b_sig;
   logic        t_pe, b_pe;
   logic [22:0] t_lock, t_down, b_lock, b_down;

   always #2.5 clk = ~clk;

   blk_prot_ctrl #(.TOP_BOOT(1'b1)) i_blk_prot_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
      .cmd_addr(cmd_addr), .wp_n(wp_n), .qry_addr(qry_addr),
      .sig_data(t_sig), .pe_allow(t_pe), .lock_bits(t_lock), .down_bits(t_down));

   blk_prot_ctrl #(.TOP_BOOT(1'b0)) i_blk_prot_ctrl_bot (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
      .cmd_addr(cmd_addr), .wp_n(wp_n), .qry_addr(qry_addr),
      .sig_data(b_sig), .pe_allow(b_pe), .lock_bits(b_lock), .down_bits(b_down));

   int    n_run = 0;
   int    n_fail = 0;
   bit    chk_en = 1'b0;
   string scen = "reset";

   // behavioural reference model of both layouts
   logic [22:0] mt_lock = '1, mt_down = '0, mb_lock = '1, mb_down = '0;
   bit          m_armed = 1'b0;

   function automatic int blk_of(int a, bit top);
      if (top) begin
         if (a >= 'h78000) return 15 + (a - 'h78000) / 4096;
         return a / 32768;
      end
      if (a < 'h8000) return a / 4096;
      return 8 + (a - 'h8000) / 32768;
   endfunction

   task automatic model_apply(inout logic [22:0] lk, inout logic [22:0] dn,
                              input int i, input logic [7:0] d, input logic wp);
      if (dn[i] && !wp) return;
      if (d == 8'h01) lk[i] = 1'b1;
      else if (d == 8'hD0) lk[i] = 1'b0;
      else if (d == 8'h2F) begin lk[i] = 1'b1; dn[i] = 1'b1; end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mt_lock = '1; mt_down = '0; mb_lock = '1; mb_down = '0; m_armed = 1'b0;
      end else if (cmd_valid) begin
         if (!m_armed) m_armed = (cmd_data == 8'h60);
         else begin
            m_armed = 1'b0;
            model_apply(mt_lock, mt_down, blk_of(int'(cmd_addr), 1'b1), cmd_data, wp_n);
            model_apply(mb_lock, mb_down, blk_of(int'(cmd_addr), 1'b0), cmd_data, wp_n);
         end
      end
   end

   task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s (%s, %s): actual %0h expected %0h", req, scen, what, act, exp);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (chk_en) begin
         int it, ib;
         it = blk_of(int'(qry_addr), 1'b1);
         ib = blk_of(int'(qry_addr), 1'b0);
         chk(t_lock === mt_lock, "R11", "top lock_bits", 32'(t_lock), 32'(mt_lock));
         chk(t_down === mt_down, "R11", "top down_bits", 32'(t_down), 32'(mt_down));
         chk(b_lock === mb_lock, "R11", "bot lock_bits", 32'(b_lock), 32'(mb_lock));
         chk(b_down === mb_down, "R11", "bot down_bits", 32'(b_down), 32'(mb_down));
         chk(t_sig === {14'b0, mt_down[it], mt_lock[it]}, "R9", "top sig_data",
             32'(t_sig), 32'({mt_down[it], mt_lock[it]}));
         chk(b_sig === {14'b0, mb_down[ib], mb_lock[ib]}, "R9", "bot sig_data",
             32'(b_sig), 32'({mb_down[ib], mb_lock[ib]}));
         chk(t_pe === !mt_lock[it], "R10", "top pe_allow", 32'(t_pe), 32'(!mt_lock[it]));
         chk(b_pe === !mb_lock[ib], "R10", "bot pe_allow", 32'(b_pe), 32'(!mb_lock[ib]));
      end
   end

   task automatic wr(logic [7:0] d, logic [18:0] a);
      @(negedge clk); #1;
      cmd_valid = 1'b1; cmd_data = d; cmd_addr = a;
      @(negedge clk); #1;
      cmd_valid = 1'b0;
   endtask

   task automatic seq2(logic [7:0] d, logic [18:0] a);
      wr(8'h60, a);
      wr(d, a);
   endtask

   task automatic do_reset();
      @(negedge clk); #1;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk); #1;
   endtask

   task automatic query(logic [18:0] a);
      @(negedge clk); #1;
      qry_addr = a;
      #1;
   endtask

   initial begin
      #(200000 * 5);
      n_run++;
      n_fail++;
      $display("FAIL watchdog (all): actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [22:0] exp_t, exp_b;
      do_reset();
      chk_en = 1'b1;

      scen = "reset";
      chk(t_lock === '1 && t_down === '0, "R3", "top after reset", 32'({t_lock, t_down}), 32'({23'h7FFFFF, 23'h0}));
      chk(b_lock === '1 && b_down === '0, "R3", "bot after reset", 32'({b_lock, b_down}), 32'({23'h7FFFFF, 23'h0}));

      scen = "sequence";
      wr(8'hD0, 19'h00000);
      chk(t_lock[0] === 1'b1, "R4", "unlock without setup", 32'(t_lock[0]), 32'd1);
      seq2(8'h55, 19'h10000);
      chk(t_lock === '1, "R4", "bad second write", 32'(t_lock), 32'h7FFFFF);
      wr(8'h60, 19'h0); wr(8'h60, 19'h0); wr(8'hD0, 19'h0);
      chk(t_lock[0] === 1'b1, "R4", "double setup then D0", 32'(t_lock[0]), 32'd1);
      seq2(8'hD0, 19'h00000);
      chk(t_lock[0] === 1'b0 && b_lock[0] === 1'b0, "R4", "unlock block 0",
          32'({t_lock[0], b_lock[0]}), 32'd0);
      seq2(8'h01, 19'h00000);
      chk(t_lock[0] === 1'b1, "R4", "relock block 0", 32'(t_lock[0]), 32'd1);

      scen = "address map";
      foreach (exp_t[i]) ;
      seq2(8'hD0, 19'h01000); seq2(8'hD0, 19'h07FFF); seq2(8'hD0, 19'h08000);
      seq2(8'hD0, 19'h77FFF); seq2(8'hD0, 19'h78000); seq2(8'hD0, 19'h7FFFF);
      exp_t = 23'h7FFFFF & ~(23'(1) | 23'(1 << 1) | 23'(1 << 14) | 23'(1 << 15) | 23'(1 << 22));
      exp_b = 23'h7FFFFF & ~(23'(1 << 1) | 23'(1 << 7) | 23'(1 << 8) | 23'(1 << 21) | 23'(1 << 22));
      chk(t_lock === exp_t, "R1", "top-boot boundary indices", 32'(t_lock), 32'(exp_t));
      chk(b_lock === exp_b, "R2", "bottom-boot boundary indices", 32'(b_lock), 32'(exp_b));
      do_reset();

      scen = "lock-down, wp low";
      wp_n = 1'b0;
      seq2(8'h2F, 19'h08000);
      chk(t_lock[1] === 1'b1 && t_down[1] === 1'b1, "R6", "top block 1 down",
          32'({t_lock[1], t_down[1]}), 32'd3);
      chk(b_down[8] === 1'b1, "R6", "bot block 8 down", 32'(b_down[8]), 32'd1);
      seq2(8'hD0, 19'h08000);
      chk(t_lock[1] === 1'b1, "R5", "unlock refused while frozen", 32'(t_lock[1]), 32'd1);
      query(19'h08000);
      chk(t_sig === 16'h0003, "R9", "signature of down block", 32'(t_sig), 32'h3);
      chk(t_pe === 1'b0, "R10", "no permission on locked block", 32'(t_pe), 32'd0);

      scen = "lock-down, wp high";
      wp_n = 1'b1;
      seq2(8'hD0, 19'h08000);
      chk(t_lock[1] === 1'b0 && t_down[1] === 1'b1, "R8", "unlock keeps down",
          32'({t_lock[1], t_down[1]}), 32'd1);
      chk(t_sig === 16'h0002, "R8", "signature unlocked+down", 32'(t_sig), 32'h2);
      chk(t_pe === 1'b1, "R10", "permission on unlocked block", 32'(t_pe), 32'd1);
      seq2(8'h2F, 19'h08000); seq2(8'hD0, 19'h08000);
      chk(t_down[1] === 1'b1, "R7", "commands never clear down", 32'(t_down[1]), 32'd1);
      wp_n = 1'b0;
      seq2(8'h01, 19'h08000);
      chk(t_lock[1] === 1'b0, "R5", "frozen in unlocked state", 32'(t_lock[1]), 32'd0);
      seq2(8'h2F, 19'h08000);
      chk(t_lock[1] === 1'b0, "R5", "lock-down refused while frozen", 32'(t_lock[1]), 32'd0);

      scen = "reset from lock-down";
      do_reset();
      chk(t_down === '0 && t_lock === '1, "R7", "reset clears down",
          32'({t_lock[1], t_down[1]}), 32'd2);
      chk(b_down === '0 && b_lock === '1, "R3", "bot reset state",
          32'({b_lock[8], b_down[8]}), 32'd2);

      repeat (3) @(negedge clk);
      chk_en = 1'b0;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule